// File: doc/BRIEF.md
# Scan Test Sequencing Controller

This controller runs scan test vectors over a set of scan chains whose lengths need not match. When `start` is seen in the idle state, it captures the vector count, the length of each chain, the capture domain and the test mode. For every vector it then does the following:

- It holds the scan enable high for as many shift cycles as the longest chain has bits.
- It gives the primary inputs their window.
- It drops scan enable for a single capture cycle, during which the clock of one selected domain is enabled.
- It goes straight back to shifting, so the captured response is unloaded while the next vector is loaded.

After the last vector comes one more shift window, which unloads the final response. A one-cycle `done` pulse closes the run.

Chains shorter than the longest one are padded at the front. Such a chain receives its shift enable only during the final `len` cycles of each window, so every chain completes on the same cycle. Stuck-at mode places a separate apply cycle between the last shift and the capture. At-speed mode has no such cycle: the last shift launches the transition, and the capture happens on the very next rising edge. All control outputs are retimed on the falling clock edge, so each one is stable across the rising edge that uses it.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is held, and in idle, `scanEn`, `domClkEn`, `chainShiftEn`, `piApply` and `done` are all 0.
- R2: Each shift window lasts exactly L cycles with `scanEn`=1 and every `domClkEn` bit at 1, where L is the largest latched chain length. Chain i is bits [i*LEN_W +: LEN_W] of `chainLen`.
- R3: Within a window, `chainShiftEn[i]` is 1 only in cycles k (counted from 0) with k >= L - len[i]. A chain of length 0 is never enabled.
- R4: In stuck-at mode (`atSpeed`=0), the last shift is followed by exactly one apply cycle: `piApply`=1, `scanEn`=0, and no domain or chain enables. The capture follows.
- R5: A capture cycle has `scanEn`=0 and no chain enables. Only `domClkEn[capDomain]` is 1; a `capDomain` of NUM_DOMAINS or more enables no domain.
- R6: In at-speed mode (`atSpeed`=1), `piApply` is 1 during the last shift cycle of each load window, and the capture cycle comes immediately after it.
- R7: After a capture that is not the last, the next shift window starts on the following cycle. After the last capture, one final unload window of L cycles runs, with `piApply` held at 0.
- R8: `done` is 1 for one cycle right after the final unload, and the block then returns to idle. If the vector count is 0, or every length is 0, `done` pulses on the cycle after `start` and `scanEn` is never raised.
- R9: Every control output changes only on a falling clock edge, so the value present just before a rising edge is still present just after it.
- R10: Inputs are latched only on a `start` seen in idle. Changes to lengths, count, domain or mode, and further `start` pulses during a run, leave the output sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (sampled in idle) |
| atSpeed | input | 1 | 1 = at-speed mode, 0 = stuck-at mode |
| vecCount | input | VEC_W | Number of vectors |
| chainLen | input | NUM_CHAINS*LEN_W | Packed chain lengths |
| capDomain | input | DOM_W | Clock domain that captures |
| scanEn | output | 1 | Scan enable |
| domClkEn | output | NUM_DOMAINS | Per-domain clock enables |
| chainShiftEn | output | NUM_CHAINS | Per-chain shift enables |
| piApply | output | 1 | Primary input apply window |
| done | output | 1 | Run complete pulse |

## Verification
A behavioural model predicts the value of every output on every clock, and the bench drives it with several stimulus patterns:

- A stuck-at run whose chain lengths include a zero, a single-bit chain and a longest chain. This separates front padding from back padding and exposes an off-by-one in the window length.
- A multi-vector at-speed run. It shows whether the apply cycle is removed and whether the launch marker falls on the last shift.
- Runs with no vectors, and runs where every length is zero. These cover the shortcut path to `done`.
- A capture domain that is out of range, to confirm that no domain is enabled.
- A run whose inputs are changed, and whose `start` is re-pulsed, partway through. This shows that the latching isolates the run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_APPLY,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch run inputs
    logic cntClr;    // clear shift counter
    logic cntInc;    // advance shift counter
    logic vecDec;    // one vector finished
    logic phShift;   // shift window cycle
    logic phLaunch;  // at-speed launch marker
    logic phApply;   // stuck-at apply cycle
    logic phCapture; // capture cycle
    logic phDone;    // completion cycle
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lastShift;
    logic lastVec;
    logic noWork;
    logic fastMode;
  } seqStatus_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t stat,
  output seqStrobe_t strb
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load   = 1'b1;
          strb.cntClr = 1'b1;
          stateNxt    = stat.noWork ? ST_DONE : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        strb.phShift = 1'b1;
        if (stat.lastShift) begin
          strb.cntClr   = 1'b1;
          strb.phLaunch = stat.fastMode;
          stateNxt      = stat.fastMode ? ST_CAPTURE : ST_APPLY;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_APPLY: begin
        strb.phApply = 1'b1;
        stateNxt     = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        strb.phCapture = 1'b1;
        strb.vecDec    = 1'b1;
        strb.cntClr    = 1'b1;
        stateNxt       = stat.lastVec ? ST_UNLOAD : ST_SHIFT;
      end
      ST_UNLOAD: begin
        strb.phShift = 1'b1;
        if (stat.lastShift) begin
          strb.cntClr = 1'b1;
          stateNxt    = ST_DONE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_DONE: begin
        strb.phDone = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS  = 4,
  parameter int LEN_W       = 6,
  parameter int VEC_W       = 8,
  parameter int NUM_DOMAINS = 3,
  parameter int DOM_W       = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        atSpeed,
  input  logic [VEC_W-1:0]            vecCount,
  input  logic [NUM_CHAINS*LEN_W-1:0] chainLen,
  input  logic [DOM_W-1:0]            capDomain,
  input  seqStrobe_t                  strb,
  output seqStatus_t                  stat,
  output logic                        scanEn,
  output logic [NUM_DOMAINS-1:0]      domClkEn,
  output logic [NUM_CHAINS-1:0]       chainShiftEn,
  output logic                        piApply,
  output logic                        done
);

  logic [LEN_W-1:0] lenQ [NUM_CHAINS];
  logic [VEC_W-1:0] vecLeft;
  logic [DOM_W-1:0] domQ;
  logic             fastQ;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] maxLen;

  // run input latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecLeft <= '0;
      domQ    <= '0;
      fastQ   <= 1'b0;
    end else if (strb.load) begin
      vecLeft <= vecCount;
      domQ    <= capDomain;
      fastQ   <= atSpeed;
    end else if (strb.vecDec) begin
      vecLeft <= vecLeft - 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_len
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          lenQ[i] <= '0;
      else if (strb.load) lenQ[i] <= chainLen[i*LEN_W +: LEN_W];
    end
  end

  // shift counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + 1'b1;
  end

  // longest chain
  always_comb begin
    maxLen = '0;
    for (int i = 0; i < NUM_CHAINS; i++) begin
      if (lenQ[i] > maxLen) maxLen = lenQ[i];
    end
  end

  assign stat.lastShift = (cnt == maxLen - 1'b1);
  assign stat.lastVec   = (vecLeft == {{(VEC_W-1){1'b0}}, 1'b1});
  assign stat.noWork    = (vecCount == '0) || (chainLen == '0);
  assign stat.fastMode  = fastQ;

  // next-cycle control decode
  logic [NUM_CHAINS-1:0]  chainNxt;
  logic [NUM_DOMAINS-1:0] domNxt;

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chain
    logic [LEN_W-1:0] padStart;
    assign padStart    = maxLen - lenQ[i];
    assign chainNxt[i] = strb.phShift && (lenQ[i] != '0) && (cnt >= padStart);
  end

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    assign domNxt[d] = strb.phShift || (strb.phCapture && (domQ == DOM_W'(d)));
  end

  // falling-edge retime: controls settle while the clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      scanEn       <= 1'b0;
      domClkEn     <= '0;
      chainShiftEn <= '0;
      piApply      <= 1'b0;
      done         <= 1'b0;
    end else begin
      scanEn       <= strb.phShift;
      domClkEn     <= domNxt;
      chainShiftEn <= chainNxt;
      piApply      <= strb.phApply | strb.phLaunch;
      done         <= strb.phDone;
    end
  end

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS  = 4,
  parameter int LEN_W       = 6,
  parameter int VEC_W       = 8,
  parameter int NUM_DOMAINS = 3,
  localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        atSpeed,
  input  logic [VEC_W-1:0]            vecCount,
  input  logic [NUM_CHAINS*LEN_W-1:0] chainLen,
  input  logic [DOM_W-1:0]            capDomain,
  output logic                        scanEn,
  output logic [NUM_DOMAINS-1:0]      domClkEn,
  output logic [NUM_CHAINS-1:0]       chainShiftEn,
  output logic                        piApply,
  output logic                        done
);

  seqStrobe_t strb;
  seqStatus_t stat;

  scan_seq_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .strb  (strb)
  );

  scan_seq_dp #(
    .NUM_CHAINS  (NUM_CHAINS),
    .LEN_W       (LEN_W),
    .VEC_W       (VEC_W),
    .NUM_DOMAINS (NUM_DOMAINS),
    .DOM_W       (DOM_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .atSpeed      (atSpeed),
    .vecCount     (vecCount),
    .chainLen     (chainLen),
    .capDomain    (capDomain),
    .strb         (strb),
    .stat         (stat),
    .scanEn       (scanEn),
    .domClkEn     (domClkEn),
    .chainShiftEn (chainShiftEn),
    .piApply      (piApply),
    .done         (done)
  );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NUM_CHAINS  = 4,
  parameter int NUM_DOMAINS = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   scanEn,
  input logic [NUM_DOMAINS-1:0] domClkEn,
  input logic [NUM_CHAINS-1:0]  chainShiftEn,
  input logic                   piApply,
  input logic                   done
);

  // R5: without scan enable at most one domain clock runs
  a_r5_single_domain: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |-> $onehot0(domClkEn));

  // R2: a chain only shifts under scan enable
  a_r2_shift_needs_se: assert property (@(posedge clk) disable iff (!rstN)
    (|chainShiftEn) |-> scanEn);

  // R4: apply cycle clocks nothing and is followed by a capture with SE low
  a_r4_apply_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (piApply && !scanEn) |-> (domClkEn == '0 && chainShiftEn == '0));

  a_r4_apply_then_capture: assert property (@(posedge clk) disable iff (!rstN)
    (piApply && !scanEn) |=> (!scanEn && !piApply));

  // R8: done is a quiet single-cycle pulse
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!scanEn && domClkEn == '0 && chainShiftEn == '0 && !piApply));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: once a padded chain starts shifting it keeps going to window end
  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chk
    a_r3_no_gap: assert property (@(posedge clk) disable iff (!rstN)
      (chainShiftEn[i] && scanEn) |=> (chainShiftEn[i] || !scanEn));
  end

endmodule

bind scan_seq_top scan_seq_chk #(
  .NUM_CHAINS  (NUM_CHAINS),
  .NUM_DOMAINS (NUM_DOMAINS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .scanEn       (scanEn),
  .domClkEn     (domClkEn),
  .chainShiftEn (chainShiftEn),
  .piApply      (piApply),
  .done         (done)
);

// File: tb/scan_seq_top_tb.sv
module scan_seq_top_tb;

  localparam int NC = 4;
  localparam int LW = 6;
  localparam int VW = 8;
  localparam int ND = 3;
  localparam int DW = 2;
  localparam int EW = 1 + ND + NC + 1 + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          atSpeed = 1'b0;
  logic [VW-1:0] vecCount = '0;
  logic [NC*LW-1:0] chainLen = '0;
  logic [DW-1:0] capDomain = '0;
  logic          scanEn;
  logic [ND-1:0] domClkEn;
  logic [NC-1:0] chainShiftEn;
  logic          piApply;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [EW-1:0] expQ[$];

  always #2.5 clk = ~clk;

  scan_seq_top #(
    .NUM_CHAINS(NC), .LEN_W(LW), .VEC_W(VW), .NUM_DOMAINS(ND)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .atSpeed(atSpeed),
    .vecCount(vecCount), .chainLen(chainLen), .capDomain(capDomain),
    .scanEn(scanEn), .domClkEn(domClkEn), .chainShiftEn(chainShiftEn),
    .piApply(piApply), .done(done)
  );

  function automatic logic [EW-1:0] outNow();
    return {scanEn, domClkEn, chainShiftEn, piApply, done};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmpAll(input string scen, input logic [EW-1:0] e);
    logic [EW-1:0] g;
    g = outNow();
    chk({scen, " R2 scanEn"},       32'(g[EW-1]),           32'(e[EW-1]));
    chk({scen, " R5 domClkEn"},     32'(g[EW-2 -: ND]),     32'(e[EW-2 -: ND]));
    chk({scen, " R3 chainShiftEn"}, 32'(g[EW-2-ND -: NC]),  32'(e[EW-2-ND -: NC]));
    chk({scen, " R4 piApply"},      32'(g[1]),              32'(e[1]));
    chk({scen, " R8 done"},         32'(g[0]),              32'(e[0]));
  endtask

  // behavioural reference: list the expected output of every cycle
  task automatic buildExp(input int lens[NC], input int nv, input int dom, input bit fast);
    int maxL = 0;
    logic [ND-1:0] allDom = '1;
    logic [ND-1:0] capDom;
    capDom = (dom < ND) ? ND'(1 << dom) : '0;
    foreach (lens[i]) if (lens[i] > maxL) maxL = lens[i];
    expQ = {};
    if (nv == 0 || maxL == 0) begin
      expQ.push_back(EW'(1));
      return;
    end
    for (int v = 0; v < nv + 1; v++) begin
      for (int k = 0; k < maxL; k++) begin
        logic [NC-1:0] ce = '0;
        logic pi;
        for (int i = 0; i < NC; i++) ce[i] = (lens[i] != 0) && (k >= maxL - lens[i]);
        pi = fast && (v < nv) && (k == maxL - 1);
        expQ.push_back({1'b1, allDom, ce, pi, 1'b0});
      end
      if (v < nv) begin
        if (!fast) expQ.push_back({1'b0, {ND{1'b0}}, {NC{1'b0}}, 1'b1, 1'b0});
        expQ.push_back({1'b0, capDom, {NC{1'b0}}, 1'b0, 1'b0});
      end
    end
    expQ.push_back(EW'(1));
  endtask

  task automatic runCase(input string scen, input int lens[NC], input int nv,
                         input int dom, input bit fast, input bit disturb);
    int idx = 0;
    buildExp(lens, nv, dom, fast);
    @(negedge clk);
    for (int i = 0; i < NC; i++) chainLen[i*LW +: LW] = LW'(lens[i]);
    vecCount  = VW'(nv);
    capDomain = DW'(dom);
    atSpeed   = fast;
    start     = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    while (expQ.size() > 0) begin
      logic [EW-1:0] e;
      logic [EW-1:0] seen;
      e = expQ.pop_front();
      @(negedge clk);
      #1;
      cmpAll(scen, e);
      seen = outNow();
      if (disturb && idx == 2) begin
        // R10: fresh inputs and a new start while busy
        chainLen  = {NC{6'd1}};
        vecCount  = 8'd9;
        capDomain = DW'(2);
        atSpeed   = ~fast;
        start     = 1'b1;
      end
      @(posedge clk);
      #1;
      // R9: outputs unchanged across the rising edge
      chk({scen, " R9 stable at rise"}, 32'(outNow()), 32'(seen));
      if (disturb && idx == 4) start = 1'b0;
      idx++;
    end
    // R1: back to idle with quiet outputs
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      #1;
      chk({scen, " R1 idle quiet"}, 32'(outNow()), 32'(0));
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lensA[NC] = '{5, 3, 0, 1};
    int lensB[NC] = '{2, 4, 4, 1};
    int lensZ[NC] = '{0, 0, 0, 0};
    int lensC[NC] = '{3, 1, 2, 3};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", 32'(outNow()), 32'(0));
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 idle after reset", 32'(outNow()), 32'(0));

    runCase("R4 R7 stuck-at padded", lensA, 2, 1, 1'b0, 1'b0);
    runCase("R6 at-speed",           lensB, 3, 0, 1'b1, 1'b0);
    runCase("R8 zero vectors",       lensA, 0, 1, 1'b0, 1'b0);
    runCase("R8 zero lengths",       lensZ, 2, 0, 1'b1, 1'b0);
    runCase("R5 domain out of range", lensC, 1, 3, 1'b0, 1'b0);
    runCase("R10 inputs changed",    lensA, 2, 0, 1'b0, 1'b1);
    runCase("R6 at-speed single",    lensC, 1, 2, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule